// File: doc/BRIEF.md
# Multiply Coprocessor Register Port

This block is a bus slave that places a multiply coprocessor in the memory map of a CPU as a window of four word registers. The CPU stores two operands and then starts the operation by writing to a control/status register. It can wait for completion in either of two ways. It can poll that register until it reads zero. It can also read the result register straight away, and the port then holds the bus with wait states until the product is available.

The bus is a simple synchronous one: an address, read and write strobes, write data, combinational read data and a ready output. The master keeps its read request asserted until ready is high and takes the data in that cycle. The multiplier is not part of the block. The port hands it a one-cycle start pulse with the two operands and takes its result when the engine raises a one-cycle done strobe.

Top module: `coprocRegIf`

## Requirements
- R1: After reset no operation is pending, the start output is low, ready is high, both operand outputs are zero, and reads of the status and result registers return zero.
- R2: A write to word offset 0 (byte address base+0) loads operand A, and a write to offset 1 (base+4) loads operand B. The new value is on the matching operand output in the cycle after the write.
- R3: A write of any value to offset 2 (base+8) while idle gives exactly one start pulse in the next cycle. From that cycle on, the status register reads 1 until the operation completes.
- R4: A status write while an operation is pending is ignored: it gives no start pulse and does not change the result that is delivered.
- R5: When the done strobe comes in during a pending operation, the product is stored in the result register, and from the next cycle the status register reads 0.
- R6: A read of offset 3 (base+12) while an operation is pending holds ready low. Ready goes high in the first cycle after completion, with the new product on the read data. With the engine latency L counted from the start pulse, a read issued one cycle after the start pulse sees exactly L wait cycles.
- R7: A result read while idle completes with no wait state and returns the last stored product.
- R8: Reads of the operand registers return zero. Writes to the result register leave its contents unchanged.
- R9: The window is the 16 bytes from base 0xA000. Accesses above the window, and accesses whose two low address bits are not zero, are ignored: operands and start are unaffected, read data is zero and ready is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| busAddr | input | ADDR_W | Byte address |
| busRd | input | 1 | Read request, held until ready |
| busWr | input | 1 | Write strobe, one cycle per write |
| busWdata | input | DATA_W | Write data |
| busRdata | output | DATA_W | Read data, valid when ready is high |
| busReady | output | 1 | Low while a result read is being stalled |
| mulStart | output | 1 | One-cycle start pulse to the engine |
| mulOpA | output | DATA_W | Operand A to the engine |
| mulOpB | output | DATA_W | Operand B to the engine |
| mulDone | input | 1 | One-cycle completion strobe from the engine |
| mulResult | input | DATA_W | Product from the engine, valid with done |

## Verification
The bound checker watches the handshake rules on every cycle. A start pulse only comes with a fresh rise of the pending flag and lasts a single cycle. Ready only drops while a read is pending, and never drops while idle. A done strobe always clears the pending flag. Accesses outside the window never move the operands or cause a start. The bench scenarios are the only way to show the data itself: that products match the arithmetic across a sweep of operands and engine latencies, that the stall length equals the latency, and that register contents survive ignored writes.

// File: rtl/coprocRegIfPkg.sv
package coprocRegIfPkg;

  typedef enum logic [1:0] {
    REG_OPA  = 2'd0,
    REG_OPB  = 2'd1,
    REG_CTRL = 2'd2,
    REG_RES  = 2'd3
  } regSel_e;

  typedef struct packed {
    logic    loadA;
    logic    loadB;
    logic    loadRes;
    logic    rdEn;
    regSel_e rdSel;
    logic    busy;
  } dpStrobe_t;

endpackage

// File: rtl/coprocRegCtl.sv
module coprocRegCtl
  import coprocRegIfPkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int OFF_LSB = 2,
  parameter logic [ADDR_W-1:0] BASE = 16'hA000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busRd,
  input  logic              busWr,
  input  logic              mulDone,
  output dpStrobe_t         strobe,
  output logic              mulStart,
  output logic              busReady
);

  localparam int WIN_LSB = OFF_LSB + 2;

  logic    inWindow;
  logic    aligned;
  logic    hit;
  regSel_e regIdx;
  logic    wrHit;
  logic    startReq;
  logic    busyQ;
  logic    startQ;

  assign aligned  = (busAddr[OFF_LSB-1:0] == '0);
  assign inWindow = (busAddr[ADDR_W-1:WIN_LSB] == BASE[ADDR_W-1:WIN_LSB]);
  assign hit      = inWindow && aligned;
  assign regIdx   = regSel_e'(busAddr[WIN_LSB-1:OFF_LSB]);
  assign wrHit    = busWr && hit;
  assign startReq = wrHit && (regIdx == REG_CTRL) && !busyQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyQ  <= 1'b0;
      startQ <= 1'b0;
    end else begin
      startQ <= startReq;
      if (startReq) begin
        busyQ <= 1'b1;
      end else if (busyQ && mulDone) begin
        busyQ <= 1'b0;
      end
    end
  end

  always_comb begin
    strobe.loadA   = wrHit && (regIdx == REG_OPA);
    strobe.loadB   = wrHit && (regIdx == REG_OPB);
    strobe.loadRes = busyQ && mulDone;
    strobe.rdEn    = busRd && hit;
    strobe.rdSel   = regIdx;
    strobe.busy    = busyQ;
  end

  assign mulStart = startQ;
  assign busReady = !(busRd && hit && (regIdx == REG_RES) && busyQ);

endmodule

// File: rtl/coprocRegDp.sv
module coprocRegDp
  import coprocRegIfPkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [DATA_W-1:0] busWdata,
  input  logic [DATA_W-1:0] mulResult,
  output logic [DATA_W-1:0] mulOpA,
  output logic [DATA_W-1:0] mulOpB,
  output logic [DATA_W-1:0] busRdata
);

  logic [DATA_W-1:0] opAQ;
  logic [DATA_W-1:0] opBQ;
  logic [DATA_W-1:0] resQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      opAQ <= '0;
      opBQ <= '0;
      resQ <= '0;
    end else begin
      if (strobe.loadA)   opAQ <= busWdata;
      if (strobe.loadB)   opBQ <= busWdata;
      if (strobe.loadRes) resQ <= mulResult;
    end
  end

  always_comb begin
    busRdata = '0;
    if (strobe.rdEn) begin
      case (strobe.rdSel)
        REG_CTRL: busRdata = {{(DATA_W-1){1'b0}}, strobe.busy};
        REG_RES:  busRdata = resQ;
        default:  busRdata = '0;
      endcase
    end
  end

  assign mulOpA = opAQ;
  assign mulOpB = opBQ;

endmodule

// File: rtl/coprocRegIf.sv
module coprocRegIf
  import coprocRegIfPkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter logic [ADDR_W-1:0] BASE = 16'hA000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busRd,
  input  logic              busWr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              busReady,
  output logic              mulStart,
  output logic [DATA_W-1:0] mulOpA,
  output logic [DATA_W-1:0] mulOpB,
  input  logic              mulDone,
  input  logic [DATA_W-1:0] mulResult
);

  localparam int OFF_LSB = $clog2(DATA_W / 8);

  dpStrobe_t ctlStrobe;

  coprocRegCtl #(
    .ADDR_W (ADDR_W),
    .OFF_LSB(OFF_LSB),
    .BASE   (BASE)
  ) ctl_i (
    .clk     (clk),
    .rstN    (rstN),
    .busAddr (busAddr),
    .busRd   (busRd),
    .busWr   (busWr),
    .mulDone (mulDone),
    .strobe  (ctlStrobe),
    .mulStart(mulStart),
    .busReady(busReady)
  );

  coprocRegDp #(
    .DATA_W(DATA_W)
  ) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (ctlStrobe),
    .busWdata (busWdata),
    .mulResult(mulResult),
    .mulOpA   (mulOpA),
    .mulOpB   (mulOpB),
    .busRdata (busRdata)
  );

endmodule

// File: rtl/coprocRegIfChk.sv
module coprocRegIfChk #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter logic [ADDR_W-1:0] BASE = 16'hA000
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busRd,
  input logic              busWr,
  input logic              busReady,
  input logic              mulStart,
  input logic              mulDone,
  input logic [DATA_W-1:0] mulOpA,
  input logic [DATA_W-1:0] mulOpB,
  input logic              busy
);

  localparam int OFF_LSB = $clog2(DATA_W / 8);
  localparam int WIN_LSB = OFF_LSB + 2;

  logic outside;
  assign outside = (busAddr[ADDR_W-1:WIN_LSB] != BASE[ADDR_W-1:WIN_LSB])
                || (busAddr[OFF_LSB-1:0] != '0);

  // R3: a start pulse comes only with the rise of the pending flag
  a_r3_start_with_busy: assert property (@(posedge clk) disable iff (!rstN)
    mulStart |-> $rose(busy));

  // R3: the start pulse lasts one cycle
  a_r3_start_one_cycle: assert property (@(posedge clk) disable iff (!rstN)
    mulStart |=> !mulStart);

  // R5: done during a pending operation clears it
  a_r5_done_clears: assert property (@(posedge clk) disable iff (!rstN)
    (busy && mulDone) |=> !busy);

  // R6: ready only drops for a read while an operation is pending
  a_r6_stall_cause: assert property (@(posedge clk) disable iff (!rstN)
    !busReady |-> (busy && busRd));

  // R7: idle means no wait state
  a_r7_idle_ready: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> busReady);

  // R9: writes outside the window touch neither operands nor start
  a_r9_outside_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && outside) |=> ($stable(mulOpA) && $stable(mulOpB) && !mulStart));

endmodule

bind coprocRegIf coprocRegIfChk #(
  .ADDR_W(ADDR_W),
  .DATA_W(DATA_W),
  .BASE  (BASE)
) chk_i (
  .clk     (clk),
  .rstN    (rstN),
  .busAddr (busAddr),
  .busRd   (busRd),
  .busWr   (busWr),
  .busReady(busReady),
  .mulStart(mulStart),
  .mulDone (mulDone),
  .mulOpA  (mulOpA),
  .mulOpB  (mulOpB),
  .busy    (ctlStrobe.busy)
);

// File: tb/coprocRegIf_tb_top.sv
module coprocRegIf_tb_top;

  localparam int AW = 16;
  localparam int DW = 32;
  localparam logic [AW-1:0] BASE = 16'hA000;
  localparam logic [AW-1:0] ADR_A   = BASE + 16'd0;
  localparam logic [AW-1:0] ADR_B   = BASE + 16'd4;
  localparam logic [AW-1:0] ADR_ST  = BASE + 16'd8;
  localparam logic [AW-1:0] ADR_RES = BASE + 16'd12;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [AW-1:0] busAddr = '0;
  logic          busRd = 1'b0;
  logic          busWr = 1'b0;
  logic [DW-1:0] busWdata = '0;
  logic [DW-1:0] busRdata;
  logic          busReady;
  logic          mulStart;
  logic [DW-1:0] mulOpA;
  logic [DW-1:0] mulOpB;
  logic          mulDone;
  logic [DW-1:0] mulResult;

  always #10 clk = ~clk;

  coprocRegIf #(.ADDR_W(AW), .DATA_W(DW), .BASE(BASE)) dut_i (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busRd(busRd), .busWr(busWr),
    .busWdata(busWdata), .busRdata(busRdata), .busReady(busReady),
    .mulStart(mulStart), .mulOpA(mulOpA), .mulOpB(mulOpB),
    .mulDone(mulDone), .mulResult(mulResult)
  );

  // stand-in engine with a run-time latency
  int            lat = 1;
  int            cnt;
  logic [DW-1:0] capA, capB;
  int            nStarts;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt <= 0; capA <= '0; capB <= '0; nStarts <= 0;
    end else if (mulStart) begin
      cnt <= lat; capA <= mulOpA; capB <= mulOpB; nStarts <= nStarts + 1;
    end else if (cnt != 0) begin
      cnt <= cnt - 1;
    end
  end
  assign mulDone   = (cnt == 1);
  assign mulResult = capA * capB;

  int nChecks = 0;
  int nFails  = 0;

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    busAddr = a; busWdata = d; busWr = 1'b1;
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] d, output int waits);
    @(negedge clk);
    busAddr = a; busRd = 1'b1; waits = 0;
    #5;
    while (!busReady && waits < 1000) begin
      waits++;
      @(negedge clk);
      #5;
    end
    d = busRdata;
    @(negedge clk);
    busRd = 1'b0;
  endtask

  function automatic logic [DW-1:0] opVal(input int i);
    case (i)
      0: return 32'h0;
      1: return 32'h1;
      2: return 32'hFFFF_FFFF;
      3: return 32'h8000_0000;
      default: return 32'h0001_2345 * i + 32'h0000_7A5B;
    endcase
  endfunction

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL R6: watchdog actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin : stim
    logic [DW-1:0] d, expProd;
    int w, s0, polls;
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;

    // R1 reset state
    #5;
    check("R1 start", {31'b0, mulStart}, 32'd0);
    check("R1 ready", {31'b0, busReady}, 32'd1);
    check("R1 opA", mulOpA, 32'd0);
    check("R1 opB", mulOpB, 32'd0);
    rd(ADR_ST, d, w);  check("R1 status", d, 32'd0);
    rd(ADR_RES, d, w); check("R1 result", d, 32'd0);
    check("R1 result waits", w, 32'd0);

    // R2 operand loads
    wr(ADR_A, 32'hDEAD_BEEF); check("R2 opA", mulOpA, 32'hDEAD_BEEF);
    wr(ADR_B, 32'h0BAD_F00D); check("R2 opB", mulOpB, 32'h0BAD_F00D);

    // R8 operand reads return zero
    rd(ADR_A, d, w); check("R8 read A", d, 32'd0);
    rd(ADR_B, d, w); check("R8 read B", d, 32'd0);

    // R9 outside and unaligned accesses
    s0 = nStarts;
    wr(BASE + 16'h10, 32'h1111_1111);
    wr(16'hB000, 32'h2222_2222);
    wr(BASE + 16'h1, 32'h3333_3333);
    wr(BASE + 16'h9, 32'h0);
    wr(BASE + 16'h18, 32'h0);
    check("R9 opA kept", mulOpA, 32'hDEAD_BEEF);
    check("R9 opB kept", mulOpB, 32'h0BAD_F00D);
    repeat (3) @(negedge clk);
    check("R9 no start", nStarts, s0);
    rd(BASE + 16'h1C, d, w); check("R9 outside read", d, 32'd0);
    check("R9 outside waits", w, 32'd0);
    rd(BASE + 16'hD, d, w);  check("R9 unaligned read", d, 32'd0);

    // R3/R6/R7/R5 blocking sweep over latency and operands
    for (int l = 1; l <= 6; l++) begin
      for (int i = 0; i < 6; i++) begin
        lat = l;
        wr(ADR_A, opVal(i));
        wr(ADR_B, opVal(5 - i + l));
        expProd = opVal(i) * opVal(5 - i + l);
        s0 = nStarts;
        wr(ADR_ST, 32'hFFFF_0000 + i);
        rd(ADR_RES, d, w);
        check("R6 product", d, expProd);
        check("R6 wait count", w, l);
        check("R3 one start", nStarts - s0, 32'd1);
        rd(ADR_RES, d, w);
        check("R7 idle reread", d, expProd);
        check("R7 no waits", w, 32'd0);
        rd(ADR_ST, d, w);
        check("R5 status idle", d, 32'd0);
      end
    end

    // R3/R5 polling mode
    for (int l = 2; l <= 8; l += 3) begin
      lat = l;
      wr(ADR_A, 32'h0000_1234 * l);
      wr(ADR_B, 32'h0000_0FED);
      expProd = (32'h0000_1234 * l) * 32'h0000_0FED;
      wr(ADR_ST, 32'h0);
      rd(ADR_ST, d, w);
      check("R3 status busy", d, 32'd1);
      polls = 0;
      while (d != 0 && polls < 50) begin
        rd(ADR_ST, d, w);
        polls++;
      end
      check("R5 status cleared", d, 32'd0);
      rd(ADR_RES, d, w);
      check("R5 polled product", d, expProd);
      check("R7 polled no waits", w, 32'd0);
    end

    // R4 restart while pending ignored
    lat = 10;
    wr(ADR_A, 32'd7);
    wr(ADR_B, 32'd9);
    s0 = nStarts;
    wr(ADR_ST, 32'd1);
    wr(ADR_A, 32'd100);
    wr(ADR_ST, 32'd2);
    rd(ADR_RES, d, w);
    check("R4 product kept", d, 32'd63);
    check("R4 single start", nStarts - s0, 32'd1);

    // R8 write to result ignored
    wr(ADR_RES, 32'h5555_AAAA);
    rd(ADR_RES, d, w);
    check("R8 result kept", d, 32'd63);

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule